// File: doc/BRIEF.md
# DRAM MR3 Multipurpose-Register Configurator

This block keeps a copy of DRAM mode register 3 and updates it on request. Three kinds of request change it: the multipurpose-register page select, the multipurpose-register enable, and the read-out format of that register. Each request carries an opcode, a two-bit value and a target rank. The block checks the value against the legal maximum for that opcode. A legal value is merged into the held image, and one mode-register-3 write goes to the command issuer. That write carries the complete updated image and an idle count equal to tMRD. An illegal value, or the reserved opcode, is answered with an error and issues nothing.

Requests come in on a valid/ready stream. `req_ready` is high only when no command is waiting at the issuer, so a request held valid while the block is busy stays pending and is not lost. Commands leave on a second valid/ready stream. A command is offered with `cmd_valid`, and its contents stay stable until the issuer raises `cmd_ready`. Each accepted request produces exactly one single-cycle `resp_valid` pulse. `resp_err` marks a rejected request.

Top module: `mpr_mr3_cfg`

## Requirements
- R1: After reset the held image is all zeros, `cmd_valid` and `resp_valid` are low and `req_ready` is high. Reset also discards a command still waiting at the issuer.
- R2: Opcode 0 (enable) accepts values 0 and 1 and writes the value to address bit A2. Values 2 and 3 are rejected.
- R3: Opcode 1 (read format) accepts values 0 to 2 and writes them to address bits A12:A11. Value 3 is rejected, so A12:A11 never hold 3.
- R4: Opcode 2 (page) accepts values 0 to 3 and writes them to address bits A1:A0.
- R5: Opcode 3 is reserved and is always rejected.
- R6: On a rejected request no command is offered, and the held image is left unchanged. The response (`resp_valid`=1, `resp_err`=1) appears in the cycle after acceptance.
- R7: On an accepted legal request a command is offered in the next cycle with `cmd_mr`=3, `cmd_idle`=tMRD and `cmd_rank` equal to the request rank. `cmd_addr` is the full image, with only the addressed field changed and every other bit unchanged (zero outside the three fields).
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command stays stable and `req_ready` is low. The cycle after the issuer takes the command, a response with `resp_err`=0 appears.
- R9: Each response lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (no command pending) |
| req_op | input | 2 | 0 enable, 1 read format, 2 page, 3 reserved |
| req_val | input | 2 | Field value |
| req_rank | input | RANK_W | Target rank |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_err | output | 1 | Invalid-parameter flag, qualified by resp_valid |
| cmd_valid | output | 1 | Mode-register write offered to the issuer |
| cmd_ready | input | 1 | Issuer takes the command |
| cmd_mr | output | 3 | Mode register number (always 3) |
| cmd_rank | output | RANK_W | Rank the write is aimed at |
| cmd_addr | output | ADDR_W | Address-bus image of MR3 |
| cmd_idle | output | IDLE_W | Idle cycles after the write (tMRD) |

## Verification
The assertions assume that the issuer obeys the valid/ready rule and that reset is asserted asynchronously and released away from a clock edge. They assume no rule about how requests are spaced. The stimulus changes inputs only on falling edges. It leaves `req_valid` high during command stalls to exercise back-pressure. It holds `cmd_ready` low for varying numbers of cycles, and it releases reset only on a falling edge.

// File: rtl/mpr_cfg_pkg.sv
package mpr_cfg_pkg;
  typedef enum logic [1:0] {
    OP_ENABLE = 2'd0,
    OP_FORMAT = 2'd1,
    OP_PAGE   = 2'd2,
    OP_RSVD   = 2'd3
  } mpr_op_e;

  localparam int          MR_SEL_W  = 3;
  localparam logic [2:0]  MR3_SEL   = 3'd3;
  localparam int          PAGE_LSB  = 0;
  localparam int          EN_BIT    = 2;
  localparam int          FMT_LSB   = 11;
  localparam logic [1:0]  LIM_EN    = 2'd1;
  localparam logic [1:0]  LIM_FMT   = 2'd2;
  localparam logic [1:0]  LIM_PAGE  = 2'd3;
endpackage

// File: rtl/mpr_req_check.sv
module mpr_req_check
  import mpr_cfg_pkg::*;
(
  input  logic [1:0] op,
  input  logic [1:0] val,
  output logic       legal
);
  always_comb begin
    unique case (mpr_op_e'(op))
      OP_ENABLE: legal = (val <= LIM_EN);
      OP_FORMAT: legal = (val <= LIM_FMT);
      OP_PAGE:   legal = (val <= LIM_PAGE);
      default:   legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mpr_mr3_image.sv
module mpr_mr3_image
  import mpr_cfg_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        op,
  input  logic [1:0]        val,
  output logic [ADDR_W-1:0] image,
  output logic [ADDR_W-1:0] merged
);
  localparam logic [ADDR_W-1:0] ONE2  = ADDR_W'(2'b11);
  localparam logic [ADDR_W-1:0] FMASK = (ONE2 << PAGE_LSB) | (ONE2 << FMT_LSB)
                                      | (ADDR_W'(1) << EN_BIT);

  always_comb begin
    merged = image;
    unique case (mpr_op_e'(op))
      OP_ENABLE: merged[EN_BIT]        = val[0];
      OP_FORMAT: merged[FMT_LSB +: 2]  = val;
      OP_PAGE:   merged[PAGE_LSB +: 2] = val;
      default:   merged = image;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     image <= '0;
    else if (wr_en) image <= merged;
  end

  AST_FMT_NEVER_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    image[FMT_LSB +: 2] != 2'b11); // R3
  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (image & ~FMASK) == '0); // R7
  AST_IMAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(image)); // R6
endmodule

// File: rtl/mpr_cmd_stage.sv
module mpr_cmd_stage
  import mpr_cfg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int RANK_W = 2,
  parameter int IDLE_W = 16,
  parameter int TMRD   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic [RANK_W-1:0]   load_rank,
  input  logic                cmd_ready,
  output logic                cmd_valid,
  output logic [MR_SEL_W-1:0] cmd_mr,
  output logic [RANK_W-1:0]   cmd_rank,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [IDLE_W-1:0]   cmd_idle,
  output logic                taken
);
  assign taken = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_rank  <= '0;
      cmd_addr  <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_rank  <= load_rank;
      cmd_addr  <= load_addr;
    end else if (taken) begin
      cmd_valid <= 1'b0;
    end
  end

  assign cmd_mr   = MR3_SEL;
  assign cmd_idle = IDLE_W'(TMRD);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_rank))); // R8
endmodule

// File: rtl/mpr_mr3_cfg.sv
module mpr_mr3_cfg
  import mpr_cfg_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int RANK_W = 2,
  parameter int IDLE_W = 16,
  parameter int TMRD   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [1:0]          req_val,
  input  logic [RANK_W-1:0]   req_rank,
  output logic                resp_valid,
  output logic                resp_err,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [MR_SEL_W-1:0] cmd_mr,
  output logic [RANK_W-1:0]   cmd_rank,
  output logic [ADDR_W-1:0]   cmd_addr,
  output logic [IDLE_W-1:0]   cmd_idle
);
  logic              legal, accept, wr_ok, taken;
  logic [ADDR_W-1:0] image, merged;

  assign req_ready = !cmd_valid;
  assign accept    = req_valid && req_ready;
  assign wr_ok     = accept && legal;

  mpr_req_check u_check (.op(req_op), .val(req_val), .legal(legal));

  mpr_mr3_image #(.ADDR_W(ADDR_W)) u_image (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .op(req_op), .val(req_val),
    .image(image), .merged(merged)
  );

  mpr_cmd_stage #(.ADDR_W(ADDR_W), .RANK_W(RANK_W), .IDLE_W(IDLE_W), .TMRD(TMRD)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(wr_ok), .load_addr(merged), .load_rank(req_rank),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_mr(cmd_mr), .cmd_rank(cmd_rank),
    .cmd_addr(cmd_addr), .cmd_idle(cmd_idle), .taken(taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
    end else begin
      resp_valid <= (accept && !legal) || taken;
      resp_err   <= accept && !legal;
    end
  end

  AST_ERR_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legal) |=> (!cmd_valid && resp_valid && resp_err)); // R6
  AST_OK_LOADS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && legal) |=> (cmd_valid && cmd_rank == $past(req_rank) && cmd_addr == image)); // R7
  AST_TAKEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (resp_valid && !resp_err)); // R8
endmodule

// File: tb/mpr_mr3_cfg_tb_top.sv
module mpr_mr3_cfg_tb_top;
  localparam int ADDR_W = 18;
  localparam int RANK_W = 2;
  localparam int IDLE_W = 16;
  localparam int TMRD   = 8;
  localparam int NV     = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, cmd_ready = 1'b0;
  logic [1:0] req_op = '0, req_val = '0;
  logic [RANK_W-1:0] req_rank = '0;
  logic req_ready, resp_valid, resp_err, cmd_valid;
  logic [2:0] cmd_mr;
  logic [RANK_W-1:0] cmd_rank;
  logic [ADDR_W-1:0] cmd_addr;
  logic [IDLE_W-1:0] cmd_idle;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mpr_mr3_cfg #(.ADDR_W(ADDR_W), .RANK_W(RANK_W), .IDLE_W(IDLE_W), .TMRD(TMRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_val(req_val), .req_rank(req_rank),
    .resp_valid(resp_valid), .resp_err(resp_err), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_mr(cmd_mr), .cmd_rank(cmd_rank),
    .cmd_addr(cmd_addr), .cmd_idle(cmd_idle)
  );

  // {op, val, rank, expect_err, expected cmd_addr}; fields A1:A0 page, A2 enable, A12:A11 format
  localparam logic [24:0] VEC [NV] = '{
    {2'd2, 2'd3, 2'd1, 1'b0, 18'h00003},  // R4 page 3
    {2'd0, 2'd1, 2'd2, 1'b0, 18'h00007},  // R2 enable
    {2'd1, 2'd2, 2'd0, 1'b0, 18'h01007},  // R3 format 2
    {2'd1, 2'd3, 2'd3, 1'b1, 18'h00000},  // R3 format 3 rejected
    {2'd3, 2'd0, 2'd1, 1'b1, 18'h00000},  // R5 reserved
    {2'd0, 2'd2, 2'd0, 1'b1, 18'h00000},  // R2 enable 2 rejected
    {2'd0, 2'd3, 2'd2, 1'b1, 18'h00000},  // R2 enable 3 rejected
    {2'd1, 2'd1, 2'd3, 1'b0, 18'h00807},  // R6 image kept after rejects
    {2'd2, 2'd0, 2'd0, 1'b0, 18'h00804},  // R4 page 0
    {2'd0, 2'd0, 2'd1, 1'b0, 18'h00800},  // R2 enable off
    {2'd1, 2'd0, 2'd2, 1'b0, 18'h00000}   // R3 format 0
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [1:0] val, input logic [1:0] rank,
                         input bit exp_err, input logic [ADDR_W-1:0] exp_addr, input int stall);
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 req_ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_op = op; req_val = val; req_rank = rank;
    @(negedge clk);
    if (exp_err) begin
      req_valid = 1'b0;
      chk(cmd_valid == 1'b0, "R6 no command on reject", 32'(cmd_valid), 32'd0);
      chk(resp_valid && resp_err, "R6 error response", 32'({resp_valid, resp_err}), 32'd3);
    end else begin
      // keep a different request offered during the stall: it must stay unaccepted
      req_op = 2'd2; req_val = 2'd1;
      chk(cmd_valid == 1'b1, "R7 command offered", 32'(cmd_valid), 32'd1);
      chk(cmd_addr == exp_addr, "R7 command address", 32'(cmd_addr), 32'(exp_addr));
      chk(cmd_rank == rank && cmd_mr == 3'd3 && cmd_idle == IDLE_W'(TMRD),
          "R7 rank/mr/idle", 32'({cmd_rank, cmd_mr, cmd_idle}), 32'({rank, 3'd3, IDLE_W'(TMRD)}));
      chk(resp_valid == 1'b0, "R8 no response before issue", 32'(resp_valid), 32'd0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(cmd_valid && cmd_addr == exp_addr && !req_ready, "R8 stall hold",
            32'(cmd_addr), 32'(exp_addr));
      end
      req_valid = 1'b0;
      cmd_ready = 1'b1;
      @(negedge clk);
      cmd_ready = 1'b0;
      chk(resp_valid && !resp_err && !cmd_valid, "R8 ok response after issue",
          32'({resp_valid, resp_err, cmd_valid}), 32'd4);
    end
    @(negedge clk);
    chk(resp_valid == 1'b0 && cmd_valid == 1'b0, "R9 single-cycle response",
        32'({resp_valid, cmd_valid}), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !resp_valid && req_ready, "R1 reset outputs",
        32'({cmd_valid, resp_valid, req_ready}), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i][24:23], VEC[i][22:21], VEC[i][20:19], VEC[i][18], VEC[i][17:0], i % 3);
    end

    // R1: reset drops a pending command and clears the image
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_val = 2'd1; req_rank = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd_valid && cmd_addr == 18'h00001, "R4 page 1", 32'(cmd_addr), 32'h1);
    rst_n = 1'b0;
    #1;
    chk(!cmd_valid && req_ready, "R1 reset clears pending", 32'(cmd_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_req(2'd0, 2'd1, 2'd0, 1'b0, 18'h00004, 0);  // R1 image zero after reset

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule